// File: doc/BRIEF.md
# Three-wire codec control bus master

This block is the master side of a three-wire serial control bus of the kind used to program audio codecs. The bus has a bit clock, a data line and a mode line. Each pin has a value output and its own output enable, so the pins can share board wiring with other two-wire devices and float when the block is idle. A host starts a transaction by giving an address byte (a 6-bit device address in bits 7:2 and a 2-bit register-space select in bits 1:0), a read-or-write flag and a byte count. Write bytes arrive on a valid/ready stream and read bytes leave on another.

The block sends the address byte with the mode line low, then moves one data byte per phase. The mode line is left high before the first data byte and pulsed low before each later one. Every phase length (clock low, clock high, mode setup, mode hold, halt pulse) is a count of system clock cycles set by a parameter. The defaults (64, 64, 48, 48, 48 cycles) meet the 250 ns and 190 ns minimums at 250 MHz. Data only moves while the bit clock is low, so a shared two-wire device never sees a start condition.

Top module: `codec_ctl3_master`

## Requirements
- R1: Each byte has 8 bits, sent or received least-significant bit first. The address byte comes first and is followed by `nbytes` data bytes. A bit is taken by the bus on each rising edge of the bit clock.
- R2: The mode line is low during all 8 address bits and goes high once the 8th address bit has been clocked.
- R3: Before the first data byte the mode line stays high. Before each later data byte it goes low once and returns high. For n data bytes the mode line therefore has n falling edges (1 when n is 0).
- R4: While the bit clock and the data enable are both high, the data output does not change. The bit clock rests high between bits and between bytes.
- R5: Each bit clock low phase lasts at least `T_LOW` system cycles, and the mode line is low for `T_MSETUP` cycles before the first address bit.
- R6: On a read, the data enable is off during every clock low phase of the data bytes. Bits are taken from `ser_dat_i` at the end of each low phase. The byte is shown on `rd_data` with `rd_valid` held, and left unchanged, until `rd_ready`. The bus waits meanwhile.
- R7: When a transaction starts, all three lines are already high in the cycle their enables first rise. When the block is idle all enables are low.
- R8: With `nbytes` = 0 only the address byte is sent, and then the pins are released.
- R9: A `start` while `busy` is high is ignored and causes no further bus activity.
- R10: `done` is high for exactly one cycle, and only when all enables were already low in the cycle before.
- R11: `wr_ready` rises only after the mode pulse and setup time for the next write byte. While it waits for `wr_valid`, the bit clock stays high.
- R12: After reset, `busy`, `done`, `wr_ready`, `rd_valid` and all three enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| rd_nwr | input | 1 | 1 = read data bytes, 0 = write |
| addr | input | 8 | Address byte: device in [7:2], space in [1:0] |
| nbytes | input | LEN_W | Number of data bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle when valid |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| ser_clk_o | output | 1 | Bit clock value |
| ser_clk_oe | output | 1 | Bit clock enable |
| ser_dat_o | output | 1 | Data line value |
| ser_dat_oe | output | 1 | Data line enable |
| ser_dat_i | input | 1 | Data line input |
| ser_mode_o | output | 1 | Mode line value |
| ser_mode_oe | output | 1 | Mode line enable |

## Verification
Every pin result follows from a register, so the bench samples pins at the rising edge of each cycle, where it sees the value registered one edge earlier. A pin-level bus model decodes bits on bit-clock rises and counts low-phase lengths from those samples. `done` is due in the cycle after the enables fall. The bench checks it at the falling edge of that cycle and of the cycle before, and checks that it is gone one cycle later. `rd_valid` and `wr_ready` can stay high for any length of time, so the bench holds the consumer or producer off for 100 to 150 cycles and checks every cycle that the bit clock stays high and the byte does not change.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,  // pins floating
    ST_ACQ,   // values high, enables rising
    ST_ASET,  // mode low, setup before address bits
    ST_LOW,   // bit clock low
    ST_HIGH,  // bit clock high
    ST_HOLD,  // mode hold after a byte
    ST_HALT,  // mode pulse low between data bytes
    ST_DSET,  // mode setup before a data byte
    ST_REL    // enables dropped
  } ccm_state_e;
endpackage

// File: rtl/ccm_rst_sync.sv
module ccm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ccm_timer.sv
module ccm_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ccm_shifter.sv
module ccm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         in_bit,
  output logic [W-1:0] q
);
  logic [W-1:0] sh_q, sh_d;
  logic         sh_en;

  assign sh_en = load || shift;

  // right shift: bit 0 leaves first, new bit enters at the top
  always_comb begin
    if (load) sh_d = load_val;
    else      sh_d = {in_bit, sh_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign q = sh_q;
endmodule

// File: rtl/codec_ctl3_master.sv
module codec_ctl3_master
  import ccm_pkg::*;
#(
  parameter int T_LOW    = 64,
  parameter int T_HIGH   = 64,
  parameter int T_MSETUP = 48,
  parameter int T_MHOLD  = 48,
  parameter int T_HALT   = 48,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_nwr,
  input  logic [7:0]       addr,
  input  logic [LEN_W-1:0] nbytes,
  output logic             busy,
  output logic             done,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             ser_clk_o,
  output logic             ser_clk_oe,
  output logic             ser_dat_o,
  output logic             ser_dat_oe,
  input  logic             ser_dat_i,
  output logic             ser_mode_o,
  output logic             ser_mode_oe
);
  localparam int T_MAX1 = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int T_MAX2 = (T_MSETUP > T_MHOLD) ? T_MSETUP : T_MHOLD;
  localparam int T_MAX3 = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
  localparam int T_MAX  = (T_MAX3 > T_HALT) ? T_MAX3 : T_HALT;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LD_LOW  = CNT_W'(T_LOW - 1);
  localparam logic [CNT_W-1:0] LD_HIGH = CNT_W'(T_HIGH - 1);
  localparam logic [CNT_W-1:0] LD_SET  = CNT_W'(T_MSETUP - 1);
  localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(T_MHOLD - 1);
  localparam logic [CNT_W-1:0] LD_HALT = CNT_W'(T_HALT - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic rst_i_n;
  ccm_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  ccm_state_e        state_q, state_d;
  logic              clk_q, clk_d, dat_q, dat_d, mode_q, mode_d;
  logic              oe_q, oe_d, doe_q, doe_d;
  logic              rd_q, rd_d, aph_q, aph_d, first_q, first_d;
  logic              rv_q, rv_d, done_q, done_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [BIT_W-1:0]  bit_q, bit_d;

  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;
  logic              sh_load, sh_shift;
  logic [BYTE_W-1:0] sh_val, sh_q;

  ccm_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp));

  ccm_shifter #(.W(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_i_n), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .in_bit(ser_dat_i), .q(sh_q));

  always_comb begin
    state_d = state_q;  clk_d = clk_q;  dat_d = dat_q;  mode_d = mode_q;
    oe_d = oe_q;  doe_d = doe_q;  rd_d = rd_q;  aph_d = aph_q;  first_d = first_q;
    rem_d = rem_q;  bit_d = bit_q;  rv_d = rv_q;  done_d = 1'b0;
    tmr_load = 1'b0;  tmr_val = '0;
    sh_load = 1'b0;  sh_val = addr;  sh_shift = 1'b0;
    wr_ready = 1'b0;
    if (rv_q && rd_ready) rv_d = 1'b0;

    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_ACQ;  clk_d = 1'b1;  dat_d = 1'b1;  mode_d = 1'b1;
        rd_d = rd_nwr;  rem_d = nbytes;  aph_d = 1'b1;  first_d = 1'b1;
        bit_d = '0;  sh_load = 1'b1;  sh_val = addr;
      end
      ST_ACQ: begin
        state_d = ST_ASET;  oe_d = 1'b1;  doe_d = 1'b1;
      end
      ST_ASET: begin
        if (mode_q) begin
          mode_d = 1'b0;  tmr_load = 1'b1;  tmr_val = LD_SET;
        end else if (tmr_exp) begin
          state_d = ST_LOW;  clk_d = 1'b0;  dat_d = sh_q[0];
          tmr_load = 1'b1;  tmr_val = LD_LOW;
        end
      end
      ST_LOW: if (tmr_exp) begin
        state_d = ST_HIGH;  clk_d = 1'b1;  sh_shift = 1'b1;
        tmr_load = 1'b1;  tmr_val = LD_HIGH;
      end
      ST_HIGH: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (bit_q != LAST_BIT) begin
          state_d = ST_LOW;  clk_d = 1'b0;  dat_d = sh_q[0];
          bit_d = bit_q + 1'b1;  tmr_val = LD_LOW;
        end else begin
          state_d = ST_HOLD;  bit_d = '0;  tmr_val = LD_HOLD;
          if (aph_q) begin
            mode_d = 1'b1;  aph_d = 1'b0;
            if (rd_q) doe_d = 1'b0;
          end else begin
            rem_d = rem_q - 1'b1;
            if (rd_q) rv_d = 1'b1;
          end
        end
      end
      ST_HOLD: if (tmr_exp && !rv_q) begin
        if (rem_q == '0) begin
          state_d = ST_REL;  oe_d = 1'b0;  doe_d = 1'b0;
        end else if (first_q) begin
          state_d = ST_DSET;  tmr_load = 1'b1;  tmr_val = LD_SET;
        end else begin
          state_d = ST_HALT;  mode_d = 1'b0;  tmr_load = 1'b1;  tmr_val = LD_HALT;
        end
      end
      ST_HALT: if (tmr_exp) begin
        state_d = ST_DSET;  mode_d = 1'b1;  tmr_load = 1'b1;  tmr_val = LD_SET;
      end
      ST_DSET: if (tmr_exp) begin
        wr_ready = !rd_q;
        if (rd_q || wr_valid) begin
          state_d = ST_LOW;  clk_d = 1'b0;  dat_d = wr_data[0];
          sh_load = !rd_q;  sh_val = wr_data;  first_d = 1'b0;
          tmr_load = 1'b1;  tmr_val = LD_LOW;
        end
      end
      ST_REL: begin
        state_d = ST_IDLE;  done_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;  clk_q <= 1'b0;  dat_q <= 1'b0;  mode_q <= 1'b0;
      oe_q <= 1'b0;  doe_q <= 1'b0;  rd_q <= 1'b0;  aph_q <= 1'b0;  first_q <= 1'b0;
      rem_q <= '0;  bit_q <= '0;  rv_q <= 1'b0;  done_q <= 1'b0;
    end else begin
      state_q <= state_d;  clk_q <= clk_d;  dat_q <= dat_d;  mode_q <= mode_d;
      oe_q <= oe_d;  doe_q <= doe_d;  rd_q <= rd_d;  aph_q <= aph_d;  first_q <= first_d;
      rem_q <= rem_d;  bit_q <= bit_d;  rv_q <= rv_d;  done_q <= done_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign rd_data     = sh_q;
  assign rd_valid    = rv_q;
  assign ser_clk_o   = clk_q;
  assign ser_clk_oe  = oe_q;
  assign ser_dat_o   = dat_q;
  assign ser_dat_oe  = doe_q;
  assign ser_mode_o  = mode_q;
  assign ser_mode_oe = oe_q;
endmodule

// File: rtl/ccm_checker.sv
module ccm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       wr_ready,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       ser_clk_o,
  input logic       ser_clk_oe,
  input logic       ser_dat_o,
  input logic       ser_dat_oe,
  input logic       ser_mode_o,
  input logic       ser_mode_oe
);
  // R4: data frozen while the bit clock is high and data is driven
  a_r4_dat_stable_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_dat_oe && $past(ser_dat_oe) && ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_dat_o));

  // R7: lines already high when enables rise
  a_r7_high_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk_oe) |-> (ser_clk_o && ser_mode_o && ser_dat_o && ser_mode_oe));

  // R10: done only with pins released, never two cycles running
  a_r10_done_pins_free: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ser_clk_oe && !ser_dat_oe && !ser_mode_oe && !$past(ser_clk_oe)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: read byte held until taken
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R11: waiting for a write byte with clock and mode high
  a_r11_ready_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (ser_clk_oe && ser_clk_o && ser_mode_o));
endmodule

bind codec_ctl3_master ccm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .wr_ready(wr_ready),
  .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .ser_clk_o(ser_clk_o), .ser_clk_oe(ser_clk_oe), .ser_dat_o(ser_dat_o),
  .ser_dat_oe(ser_dat_oe), .ser_mode_o(ser_mode_o), .ser_mode_oe(ser_mode_oe));

// File: tb/codec_ctl3_master_test.sv
`timescale 1ns/1ps
module codec_ctl3_master_test;
  localparam int T_LOW_CYC = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd_nwr = 1'b0, rd_ready = 1'b0, ser_dat_i;
  logic [7:0] addr = 8'h00;
  logic [7:0] nbytes = 8'h00;
  logic busy, done, wr_ready, rd_valid;
  logic [7:0] wr_data, rd_data;
  logic wr_valid;
  logic ser_clk_o, ser_clk_oe, ser_dat_o, ser_dat_oe, ser_mode_o, ser_mode_oe;

  always #2 clk = ~clk;  // 250 MHz

  codec_ctl3_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .addr(addr), .nbytes(nbytes),
    .busy(busy), .done(done), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .ser_clk_o(ser_clk_o), .ser_clk_oe(ser_clk_oe), .ser_dat_o(ser_dat_o),
    .ser_dat_oe(ser_dat_oe), .ser_dat_i(ser_dat_i), .ser_mode_o(ser_mode_o),
    .ser_mode_oe(ser_mode_oe));

  int checks = 0, failures = 0;
  logic clr = 1'b1, stall = 1'b0, rd_txn = 1'b0;

  // write byte source
  logic [7:0] wq [0:7];
  int wn = 0, widx;
  assign wr_valid = !stall && (widx < wn);
  assign wr_data  = (widx < wn) ? wq[widx[2:0]] : 8'h00;
  always @(posedge clk)
    if (clr) widx <= 0;
    else if (wr_valid && wr_ready) widx <= widx + 1;

  // read byte sink
  logic [7:0] rgot [0:7];
  int rn;
  always @(posedge clk)
    if (clr) rn <= 0;
    else if (rd_valid && rd_ready) begin
      rgot[rn[2:0]] <= rd_data;
      rn <= rn + 1;
    end

  // pin-level bus model
  logic [7:0] slv [0:7];
  logic [7:0] mon_b [0:7];
  logic       mode_at [0:7];
  logic [7:0] cur;
  int mon_nb, mon_bn, falls, i2c_bad, acq_bad, short_low, lowcnt, rd_oe_bad;
  logic p_clk, p_coe, p_mode, p_moe, p_dat, p_doe, bitv;

  always_comb begin
    if (mon_nb >= 1 && mon_nb <= 8) ser_dat_i = slv[3'(mon_nb - 1)][mon_bn[2:0]];
    else ser_dat_i = 1'b0;
  end

  always @(posedge clk) begin
    p_clk <= ser_clk_o;  p_coe <= ser_clk_oe;  p_mode <= ser_mode_o;
    p_moe <= ser_mode_oe;  p_dat <= ser_dat_o;  p_doe <= ser_dat_oe;
    if (clr) begin
      mon_nb <= 0; mon_bn <= 0; cur <= 8'h00; falls <= 0; i2c_bad <= 0; acq_bad <= 0;
      short_low <= 0; lowcnt <= 0; rd_oe_bad <= 0;
    end else begin
      if (ser_clk_oe && (p_coe === 1'b0) && !(ser_clk_o && ser_mode_o && ser_dat_o))
        acq_bad <= acq_bad + 1;
      if (ser_mode_oe && p_moe && p_mode && !ser_mode_o) falls <= falls + 1;
      if (ser_dat_oe && p_doe && ser_clk_oe && ser_clk_o && p_clk && (ser_dat_o != p_dat))
        i2c_bad <= i2c_bad + 1;
      if (rd_txn && mon_nb >= 1 && ser_dat_oe && ser_clk_oe && !ser_clk_o)
        rd_oe_bad <= rd_oe_bad + 1;
      if (ser_clk_oe && !ser_clk_o) lowcnt <= lowcnt + 1;
      if (ser_clk_oe && ser_clk_o && (p_clk === 1'b0)) begin
        if (lowcnt < T_LOW_CYC) short_low <= short_low + 1;
        lowcnt <= 0;
        bitv = ser_dat_oe ? ser_dat_o : ser_dat_i;
        if (mon_bn == 0 && mon_nb < 8) mode_at[mon_nb[2:0]] <= ser_mode_o;
        if (mon_bn == 7) begin
          if (mon_nb < 8) mon_b[mon_nb[2:0]] <= cur | ({7'd0, bitv} << 7);
          mon_nb <= mon_nb + 1;  mon_bn <= 0;  cur <= 8'h00;
        end else begin
          cur <= cur | ({7'd0, bitv} << mon_bn);
          mon_bn <= mon_bn + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_txn(input bit rd, input logic [7:0] a, input int n);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    rd_txn = rd;  rd_nwr = rd;  addr = a;  nbytes = 8'(n);  start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // waits for done; optionally pokes start while busy at cycle poke_at
  task automatic wait_done(input int poke_at);
    int cyc = 0;
    bit prev_free = 1'b0;
    while (done !== 1'b1 && cyc < 100000) begin
      prev_free = !ser_clk_oe && !ser_dat_oe && !ser_mode_oe;
      @(negedge clk);
      cyc++;
      if (cyc == poke_at) begin
        start = 1'b1; rd_nwr = 1'b1; addr = 8'hFF; nbytes = 8'd5;
      end else if (cyc == poke_at + 1) start = 1'b0;
    end
    chk(prev_free && !ser_clk_oe && !ser_dat_oe && !ser_mode_oe,
        "R10 pins released before done", int'(ser_clk_oe), 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
  endtask

  task automatic check_write(input logic [7:0] a, input int n, input string tag);
    chk(mon_nb == n + 1, {tag, " R1 byte count"}, mon_nb, n + 1);
    chk(mon_b[0] == a, {tag, " R1 address byte"}, int'(mon_b[0]), int'(a));
    for (int k = 0; k < n; k++)
      chk(mon_b[k+1] == wq[k], {tag, " R1 data byte"}, int'(mon_b[k+1]), int'(wq[k]));
    chk(mode_at[0] == 1'b0, {tag, " R2 mode low in address"}, int'(mode_at[0]), 0);
    if (n > 0) chk(mode_at[1] == 1'b1, {tag, " R2 mode high in data"}, int'(mode_at[1]), 1);
    chk(falls == ((n == 0) ? 1 : n), {tag, " R3 mode falls"}, falls, (n == 0) ? 1 : n);
    chk(i2c_bad == 0, {tag, " R4 data moved with clock high"}, i2c_bad, 0);
    chk(short_low == 0, {tag, " R5 short clock low"}, short_low, 0);
    chk(acq_bad == 0, {tag, " R7 enable before high"}, acq_bad, 0);
  endtask

  task automatic test_reset();
    chk(!busy && !done && !wr_ready && !rd_valid, "R12 reset status", int'(busy), 0);
    chk(!ser_clk_oe && !ser_dat_oe && !ser_mode_oe, "R12 reset enables", int'(ser_clk_oe), 0);
  endtask

  task automatic test_write3();
    wq[0] = 8'hA5; wq[1] = 8'h3C; wq[2] = 8'h81; wn = 3;
    start_txn(1'b0, {6'd23, 2'b10}, 3);
    wait_done(300);
    check_write({6'd23, 2'b10}, 3, "write3");
    repeat (40) @(negedge clk);
    chk(!busy && !ser_clk_oe && mon_nb == 4, "R9 start while busy ignored", mon_nb, 4);
  endtask

  task automatic test_zero();
    wn = 0;
    start_txn(1'b0, 8'h1F, 0);
    wait_done(-5);
    check_write(8'h1F, 0, "R8 zero");
  endtask

  task automatic test_single();
    wq[0] = 8'h6D; wn = 1;
    start_txn(1'b0, 8'h42, 1);
    wait_done(-5);
    check_write(8'h42, 1, "R3 single");
  endtask

  task automatic test_stall();
    int bad = 0;
    int guard = 0;
    wq[0] = 8'h0F; wq[1] = 8'hF0; wn = 2; stall = 1'b1;
    start_txn(1'b0, 8'h9B, 2);
    while (wr_ready !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    chk(mon_nb == 1 && falls == 1, "R11 ready after address and setup", mon_nb, 1);
    for (int c = 0; c < 150; c++) begin
      @(negedge clk);
      if (!(wr_ready && ser_clk_o && ser_clk_oe)) bad++;
    end
    chk(bad == 0, "R11 clock high while stalled", bad, 0);
    stall = 1'b0;
    wait_done(-5);
    check_write(8'h9B, 2, "R11 stall");
  endtask

  task automatic test_read();
    int bad = 0;
    int guard = 0;
    slv[0] = 8'hC3; slv[1] = 8'h6E; wn = 0; rd_ready = 1'b0;
    start_txn(1'b1, 8'h57, 2);
    while (rd_valid !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (!(rd_valid && rd_data == 8'hC3 && ser_clk_o)) bad++;
    end
    chk(bad == 0, "R6 byte held until taken", bad, 0);
    rd_ready = 1'b1;
    wait_done(-5);
    rd_ready = 1'b0;
    chk(rn == 2, "R6 read byte count", rn, 2);
    chk(rgot[0] == 8'hC3, "R6 read byte 0", int'(rgot[0]), 8'hC3);
    chk(rgot[1] == 8'h6E, "R6 read byte 1", int'(rgot[1]), 8'h6E);
    chk(rd_oe_bad == 0, "R6 data enable off in read bytes", rd_oe_bad, 0);
    chk(mon_b[0] == 8'h57 && falls == 2, "R3 read mode pulses", falls, 2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_write3();
    test_zero();
    test_single();
    test_stall();
    test_read();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule